// File: doc/BRIEF.md
# Bidirectional GPIO Port with Per-Nibble Alternate Functions

This block is an eight-pin general-purpose I/O port driven from a simple register bus. Software writes an output data latch and a direction register and reads back either the latch, the direction register, or the synchronized levels seen on the pins. Each pin is presented to the pad ring as an output value, an output enable and an input level, so the pad tristate lives outside the block.

The two halves of the port can be lent to other functions. The upper four pins can be placed in analog-input mode, where the port stops driving them and reads them as zero so that the analog sampling path sees an undisturbed pad. The lower four pins can be handed to an external-memory address bus, where the top address nibble drives them in place of the latch. Two configuration inputs, one for each half, choose between port use and the alternate function; both are registered, and reset gives both halves to their alternate functions while leaving every port-owned pin undriven.

Top module: `gpio_mux_port`

## Requirements
- R1: A write with reg_sel 0 (port) or reg_sel 1 (latch) loads wdata into the output latch at the next clock edge; a read with reg_sel 1 returns the latch contents, not the pin levels.
- R2: A write with reg_sel 2 loads the direction register at the next clock edge, and a read with reg_sel 2 returns it; a direction bit of 1 means input.
- R3: For a pin owned by the port, a direction bit of 0 sets pin_oe to 1 and pin_out to the latch bit; a direction bit of 1 sets pin_oe to 0.
- R4: A read with reg_sel 0 returns the pin levels through a two-stage synchronizer: a change on pin_in applied between edges shows on rdata after the second following rising edge and not after the first.
- R5: While the upper half is in analog mode, pin_oe[7:4] is 0 whatever the direction register holds, and a port read returns 0 in bits 7:4.
- R6: While the lower half is in bus mode, pin_out[3:0] equals bus_addr and pin_oe[3:0] is all ones whatever the latch and direction hold.
- R7: hi_analog_cfg (1 = analog) and lo_bus_cfg (1 = bus) are registered: a change takes effect on the outputs one clock edge after it is applied, not before.
- R8: While reset is held, the latch reads 0, the direction register reads 0xFF, pin_oe[7:4] is 0 and the lower half is in bus mode (pin_oe[3:0] all ones, pin_out[3:0] equal to bus_addr).
- R9: rdata is 0 when rd_en is low, and also for reg_sel 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| reg_sel | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the selected source |
| hi_analog_cfg | input | 1 | 1 puts pins 7:4 in analog-input mode |
| lo_bus_cfg | input | 1 | 1 gives pins 3:0 to the memory address bus |
| bus_addr | input | 4 | Address bits 19:16 from the memory interface |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The assertions take for granted that the bus strobes, register select, write data and the two configuration inputs are synchronous to clk and settled before each rising edge, and that pin_in, though asynchronous in use, holds its value across the sampling edges the synchronizer check compares. The bench changes every input half a period away from the rising edge and samples outputs at that same point, so no input moves near an edge. Writes and reads are never issued together, and reset is released on a falling edge, so the synchronized reset release is deterministic.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    SEL_PORT  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_NONE  = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ni = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_smp
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = pin_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign pin_smp = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      // R4: sample seen two edges after the pin level
      assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_ni)
        $past(rst_ni, 2) |-> (pin_smp == $past(pin_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  gpio_sel_e        sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  input  logic             hi_analog_cfg,
  input  logic             lo_bus_cfg,
  output logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] dir_q,
  output logic             hi_ana_q,
  output logic             lo_bus_q
);
  logic             lat_we;
  logic             dir_we;
  logic [WIDTH-1:0] lat_d;
  logic [WIDTH-1:0] dir_d;

  always_comb begin
    lat_we = wr_en && ((sel == SEL_PORT) || (sel == SEL_LATCH));
    dir_we = wr_en && (sel == SEL_DIR);
    lat_d  = lat_we ? wdata : lat_q;
    dir_d  = dir_we ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q    <= '0;
      dir_q    <= '1;
      hi_ana_q <= 1'b1;
      lo_bus_q <= 1'b1;
    end else begin
      lat_q    <= lat_d;
      dir_q    <= dir_d;
      hi_ana_q <= hi_analog_cfg;
      lo_bus_q <= lo_bus_cfg;
    end
  end

  // R1: port or latch write loads the latch
  assert_latch_load_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (sel == SEL_PORT || sel == SEL_LATCH)) |=> (lat_q == $past(wdata)));
  // R1: latch holds without a write to it
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_en && (sel == SEL_PORT || sel == SEL_LATCH)) |=> $stable(lat_q));
  // R2: direction write loads the direction register
  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && sel == SEL_DIR) |=> (dir_q == $past(wdata)));
  // R7: configuration inputs register after one edge
  assert_mode_load_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(rst_ni) |-> (hi_ana_q == $past(hi_analog_cfg) && lo_bus_q == $past(lo_bus_cfg)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int WIDTH = 8,
  parameter int LO_W  = 4
) (
  input  logic             hi_ana,
  input  logic             lo_bus,
  input  logic [LO_W-1:0]  bus_addr,
  input  logic [WIDTH-1:0] lat,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] pin_smp,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] port_rd
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      if (i < LO_W) begin : g_bus
        always_comb begin
          pin_out[i] = lo_bus ? bus_addr[i] : lat[i];
          pin_oe[i]  = lo_bus | ~dir[i];
          port_rd[i] = pin_smp[i];
        end
      end else begin : g_ana
        always_comb begin
          pin_out[i] = hi_ana ? 1'b0 : lat[i];
          pin_oe[i]  = ~hi_ana & ~dir[i];
          port_rd[i] = ~hi_ana & pin_smp[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int LO_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             hi_analog_cfg,
  input  logic             lo_bus_cfg,
  input  logic [LO_W-1:0]  bus_addr,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  localparam int HI_W = WIDTH - LO_W;

  logic             rst_ni;
  gpio_sel_e        sel;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;
  logic             hi_ana_q;
  logic             lo_bus_q;
  logic [WIDTH-1:0] pin_smp;
  logic [WIDTH-1:0] port_rd;

  assign sel = gpio_sel_e'(reg_sel);

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .sel(sel), .wr_en(wr_en), .wdata(wdata),
    .hi_analog_cfg(hi_analog_cfg), .lo_bus_cfg(lo_bus_cfg),
    .lat_q(lat_q), .dir_q(dir_q), .hi_ana_q(hi_ana_q), .lo_bus_q(lo_bus_q)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .pin_in(pin_in), .pin_smp(pin_smp)
  );

  gpio_pin_mux #(.WIDTH(WIDTH), .LO_W(LO_W)) u_mux (
    .hi_ana(hi_ana_q), .lo_bus(lo_bus_q), .bus_addr(bus_addr),
    .lat(lat_q), .dir(dir_q), .pin_smp(pin_smp),
    .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_PORT:  rdata = port_rd;
        SEL_LATCH: rdata = lat_q;
        SEL_DIR:   rdata = dir_q;
        default:   rdata = '0;
      endcase
    end
  end

  // R3: input-direction pins owned by the port are never driven
  assert_input_hiz_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ((pin_oe[WIDTH-1:LO_W] & dir_q[WIDTH-1:LO_W] & {HI_W{~hi_ana_q}}) == '0) &&
    (lo_bus_q || ((pin_oe[LO_W-1:0] & dir_q[LO_W-1:0]) == '0)));
  // R5: analog half is undriven and reads zero
  assert_analog_off_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    hi_ana_q |-> (pin_oe[WIDTH-1:LO_W] == '0 &&
                  (!(rd_en && sel == SEL_PORT) || rdata[WIDTH-1:LO_W] == '0)));
  // R6: bus half follows the address nibble
  assert_bus_drive_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    lo_bus_q |-> (pin_oe[LO_W-1:0] == '1 && pin_out[LO_W-1:0] == bus_addr));
  // R9: no read data without a read strobe
  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rd_en || sel == SEL_NONE) |-> (rdata == '0));
endmodule

// File: tb/gpio_mux_port_tb.sv
module gpio_mux_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_sel;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       hi_analog_cfg, lo_bus_cfg;
  logic [3:0] bus_addr;
  logic [7:0] pin_in, pin_out, pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_mux_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .hi_analog_cfg(hi_analog_cfg),
    .lo_bus_cfg(lo_bus_cfg), .bus_addr(bus_addr), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    reg_sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] v);
    reg_sel = s; rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_addr = 4'hA;
    #1;
    rd(2'd1, v); check("R8 latch in reset", v, 8'h00);
    rd(2'd2, v); check("R8 dir in reset", v, 8'hFF);
    check("R8 oe in reset", pin_oe, 8'h0F);
    check("R8 bus addr in reset", {4'h0, pin_out[3:0]}, 8'h0A);
  endtask

  task automatic t_latch_dir();
    logic [7:0] v;
    hi_analog_cfg = 1'b0; lo_bus_cfg = 1'b0;
    cyc(1);
    pin_in = 8'h00;
    wr(2'd0, 8'h5C);
    rd(2'd1, v); check("R1 port-address write to latch", v, 8'h5C);
    wr(2'd1, 8'hA3);
    rd(2'd1, v); check("R1 latch-address write", v, 8'hA3);
    cyc(3);
    rd(2'd1, v); check("R1 latch read ignores pins", v, 8'hA3);
    wr(2'd2, 8'h3C);
    rd(2'd2, v); check("R2 dir readback", v, 8'h3C);
  endtask

  task automatic t_drive();
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'hF0);
    check("R3 oe follows dir", pin_oe, 8'h0F);
    check("R3 out follows latch", pin_out & pin_oe, 8'h05);
    wr(2'd2, 8'h0F);
    check("R3 oe upper", pin_oe, 8'hF0);
    check("R3 out upper", pin_out & pin_oe, 8'hA0);
  endtask

  task automatic t_pin_read();
    logic [7:0] v;
    wr(2'd2, 8'hFF);
    pin_in = 8'h00; cyc(3);
    pin_in = 8'h96;
    cyc(1);
    rd(2'd0, v); check("R4 not visible after one edge", v, 8'h00);
    cyc(1);
    rd(2'd0, v); check("R4 visible after two edges", v, 8'h96);
  endtask

  task automatic t_analog();
    logic [7:0] v;
    wr(2'd2, 8'h00);
    hi_analog_cfg = 1'b1; pin_in = 8'hFF;
    cyc(3);
    check("R5 analog undriven", pin_oe & 8'hF0, 8'h00);
    rd(2'd0, v); check("R5 analog reads zero", v, 8'h0F);
    hi_analog_cfg = 1'b0;
    cyc(1);
  endtask

  task automatic t_bus();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    lo_bus_cfg = 1'b1; bus_addr = 4'h6;
    cyc(1);
    check("R6 bus oe", pin_oe & 8'h0F, 8'h0F);
    check("R6 bus addr", pin_out & 8'h0F, 8'h06);
    bus_addr = 4'h9; #1;
    check("R6 bus addr follows", pin_out & 8'h0F, 8'h09);
    lo_bus_cfg = 1'b0;
    cyc(1);
  endtask

  task automatic t_mode_timing();
    wr(2'd2, 8'h00);
    hi_analog_cfg = 1'b1; #1;
    check("R7 before edge", pin_oe & 8'hF0, 8'hF0);
    cyc(1);
    check("R7 after edge", pin_oe & 8'hF0, 8'h00);
    hi_analog_cfg = 1'b0;
    cyc(1);
  endtask

  task automatic t_rd_idle();
    logic [7:0] v;
    wr(2'd1, 8'hC3);
    reg_sel = 2'd1; rd_en = 1'b0; #1;
    check("R9 idle read", rdata, 8'h00);
    rd(2'd3, v); check("R9 unused select", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    hi_analog_cfg = 1'b1; lo_bus_cfg = 1'b1; bus_addr = 4'h0; pin_in = 8'h00;
    cyc(2);
    t_reset();
    rst_n = 1'b1;
    cyc(3);
    t_latch_dir();
    t_drive();
    t_pin_read();
    t_analog();
    t_bus();
    t_mode_timing();
    t_rd_idle();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule